// File: doc/BRIEF.md
# CAN Controller Command-Register Port over SPI

This block is the host-side register port of a CAN controller. A host talks to it over a byte-wide SPI slave link. Within each chip-select frame, the first byte is a one-byte command code and not an address. Every register has its own read code and its own write code. For a read, the register value is shifted out on MISO during the second byte. For a write, the second byte carries the new value. One further code, sent alone, puts the register set back into its initial state.

The block holds the operating-mode field, the transmit enable and the two bit-timing bytes, and passes them to the protocol engine on dedicated outputs. The interrupt flags and the error flags are set from input pulses. Each flag stays set until a host read reports it, and the read clears exactly the bits that it returned. The status byte and the two error counters come in from ports. An interrupt output stays high for as long as any enabled interrupt flag is set. The SPI pins are synchronised into the system clock, so SCLK must run several times slower than `clk`.

Top module: `can_spi_regif`

## Requirements
- R1: The write codes 0x18 and 0x1A store the second frame byte into the first and second bit-timing registers. The read codes 0xD6 and 0xD8 return those registers, and the outputs `btr0_o` and `btr1_o` show them.
- R2: The control-0 register is written with code 0x14 and read with code 0xD2. Bits 7:5 of this register are the mode field and drive `mode_o`. The mode codes are 0 normal, 1 loopback, 2 monitor, 3 sleep and 4 init. After `rst_n`, the register reads 0x80, which is init mode.
- R3: The status code 0xE2 returns the fixed value 0x82 while the mode is init. In any other mode it returns `stat_live_i`.
- R4: Code 0x56 is a frame of one byte. It sets control-0 to 0x80 and clears control-1, the interrupt-enable register, both bit-timing registers and the interrupt flags. It leaves the error-flag register unchanged.
- R5: `err_set_i` pulses OR into the error-flag register. A complete read with code 0xDC returns the register and then clears the bits that were returned.
- R6: The interrupt-enable register is written with code 0x1C. `irq_o` is high exactly while the bitwise AND of the interrupt flags and the interrupt-enable register is nonzero.
- R7: `int_set_i` pulses OR into the interrupt-flag register. A complete read with code 0xDE returns the flags and then clears the bits that were returned.
- R8: If chip-select is released before the eighth SCLK edge of the second byte, the frame writes no register and clears no flag.
- R9: The code 0xEA returns `rec_i`, and the code 0xEC returns `tec_i`.
- R10: A code that is not assigned returns 0x00 and changes no register.
- R11: Control-1 is written with code 0x16 and read with code 0xD4. Bit 7 of this register drives `tx_en_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, clears every register |
| spi_sclk | input | 1 | SPI clock, mode 0 |
| spi_cs_n | input | 1 | SPI chip-select, active low |
| spi_mosi | input | 1 | Serial data from the host, MSB first |
| spi_miso | output | 1 | Serial data to the host, MSB first |
| stat_live_i | input | 8 | Status byte from the protocol engine |
| err_set_i | input | 8 | Error-flag set pulses |
| int_set_i | input | 8 | Interrupt-flag set pulses |
| rec_i | input | 8 | Receive error counter |
| tec_i | input | 8 | Transmit error counter |
| mode_o | output | 3 | Operating mode field |
| tx_en_o | output | 1 | Transmit enable |
| btr0_o | output | 8 | Bit-timing byte 0 |
| btr1_o | output | 8 | Bit-timing byte 1 |
| irq_o | output | 1 | Level interrupt request |

## Verification
The assertions assume that the flag set ports carry one-cycle pulses, and that SCLK and chip-select change slowly enough for every synchronised edge to be seen on its own. The bench therefore holds each SCLK half period for eight system clocks. It changes MOSI only while SCLK is low, and it raises set pulses only between frames, so that a set never coincides with the clear of the same flag. The bench also assumes a legal mode field, and writes only the mode codes that are defined.

// File: rtl/can_spi_pkg.sv
package can_spi_pkg;
  localparam int unsigned BYTE_W = 8;

  localparam logic [7:0] OP_MASTER_RST = 8'h56;
  localparam logic [7:0] OP_RD_CTRL0   = 8'hD2;
  localparam logic [7:0] OP_RD_CTRL1   = 8'hD4;
  localparam logic [7:0] OP_RD_STAT    = 8'hE2;
  localparam logic [7:0] OP_RD_BTR0    = 8'hD6;
  localparam logic [7:0] OP_RD_BTR1    = 8'hD8;
  localparam logic [7:0] OP_RD_INTF    = 8'hDE;
  localparam logic [7:0] OP_RD_ERR     = 8'hDC;
  localparam logic [7:0] OP_RD_REC     = 8'hEA;
  localparam logic [7:0] OP_RD_TEC     = 8'hEC;
  localparam logic [7:0] OP_WR_CTRL0   = 8'h14;
  localparam logic [7:0] OP_WR_CTRL1   = 8'h16;
  localparam logic [7:0] OP_WR_IE      = 8'h1C;
  localparam logic [7:0] OP_WR_BTR0    = 8'h18;
  localparam logic [7:0] OP_WR_BTR1    = 8'h1A;

  typedef enum logic [2:0] {
    MODE_NORMAL   = 3'd0,
    MODE_LOOPBACK = 3'd1,
    MODE_MONITOR  = 3'd2,
    MODE_SLEEP    = 3'd3,
    MODE_INIT     = 3'd4
  } op_mode_e;

  localparam logic [7:0] CTRL0_RESET = {MODE_INIT, 5'b0};
  localparam logic [7:0] STAT_RESET  = 8'h82;

  // Sticky flag update: drop reported bits, then add new events.
  function automatic logic [7:0] flag_update(input logic [7:0] cur,
                                             input logic [7:0] clr,
                                             input logic [7:0] set);
    return (cur & ~clr) | set;
  endfunction

  function automatic logic [2:0] mode_field(input logic [7:0] ctrl0);
    return ctrl0[7:5];
  endfunction
endpackage

// File: rtl/spi_sync_front.sv
module spi_sync_front #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_raw,
  input  logic cs_n_raw,
  input  logic mosi_raw,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_active,
  output logic mosi_s
);
  localparam int unsigned NSIG = 3;
  localparam logic [NSIG-1:0] RST_VAL = 3'b010; // cs_n idles high

  logic [NSIG-1:0] raw;
  logic [NSIG-1:0] synced;
  logic            sclk_prev;

  assign raw = {mosi_raw, cs_n_raw, sclk_raw};

  for (genvar g = 0; g < NSIG; g++) begin : g_sync
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= {STAGES{RST_VAL[g]}};
      else        pipe <= {pipe[STAGES-2:0], raw[g]};
    end
    assign synced[g] = pipe[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_prev <= 1'b0;
    else        sclk_prev <= synced[0];
  end

  assign sclk_rise = synced[0] & ~sclk_prev;
  assign sclk_fall = ~synced[0] & sclk_prev;
  assign cs_active = ~synced[1];
  assign mosi_s    = synced[2];
endmodule

// File: rtl/spi_byte_engine.sv
module spi_byte_engine #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              cs_active,
  input  logic              mosi_s,
  input  logic              load_en,
  input  logic [BYTE_W-1:0] load_data,
  output logic              byte_vld,
  output logic [BYTE_W-1:0] byte_data,
  output logic [1:0]        byte_idx,
  output logic              miso
);
  localparam int unsigned CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic [BYTE_W-1:0] sh_in;
  logic [BYTE_W-1:0] sh_out;
  logic [CNT_W-1:0]  bit_cnt;
  logic [1:0]        byte_cnt;

  assign byte_vld  = cs_active & sclk_rise & (bit_cnt == LAST_BIT);
  assign byte_data = {sh_in[BYTE_W-2:0], mosi_s};
  assign byte_idx  = byte_cnt;
  assign miso      = cs_active & sh_out[BYTE_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_in    <= '0;
      sh_out   <= '0;
      bit_cnt  <= '0;
      byte_cnt <= '0;
    end else if (!cs_active) begin
      sh_out   <= '0;
      bit_cnt  <= '0;
      byte_cnt <= '0;
    end else begin
      if (sclk_rise) begin
        sh_in   <= byte_data;
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == LAST_BIT && byte_cnt != 2'd3) byte_cnt <= byte_cnt + 2'd1;
      end
      // No shift on the falling edge that closes a byte: the freshly
      // loaded MSB must stay on the line for the next rising edge.
      if (load_en)                         sh_out <= load_data;
      else if (sclk_fall && bit_cnt != '0) sh_out <= {sh_out[BYTE_W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/can_reg_core.sv
module can_reg_core
  import can_spi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       byte_vld,
  input  logic [7:0] byte_data,
  input  logic [1:0] byte_idx,
  input  logic [7:0] stat_live_i,
  input  logic [7:0] err_set_i,
  input  logic [7:0] int_set_i,
  input  logic [7:0] rec_i,
  input  logic [7:0] tec_i,
  output logic       load_en,
  output logic [7:0] load_data,
  output logic [2:0] mode_o,
  output logic       tx_en_o,
  output logic [7:0] btr0_o,
  output logic [7:0] btr1_o,
  output logic       irq_o,
  output logic [7:0] intf_flags,
  output logic [7:0] err_flags,
  output logic       evt_mst_reset,
  output logic       evt_ctrl0_wr,
  output logic       evt_ie_wr,
  output logic       evt_intf_clr,
  output logic       evt_err_clr
);
  logic [7:0] ctrl0_q, ctrl1_q, ie_q, btr0_q, btr1_q, intf_q, err_q;
  logic [7:0] opc_q, snap_q;
  logic       first_b, second_b;
  logic       evt_ctrl1_wr, evt_btr0_wr, evt_btr1_wr;
  logic [7:0] rd_val, stat_val;

  assign first_b  = byte_vld && byte_idx == 2'd0;
  assign second_b = byte_vld && byte_idx == 2'd1;

  assign evt_mst_reset = first_b  && byte_data == OP_MASTER_RST;
  assign evt_ctrl0_wr  = second_b && opc_q == OP_WR_CTRL0;
  assign evt_ctrl1_wr  = second_b && opc_q == OP_WR_CTRL1;
  assign evt_ie_wr     = second_b && opc_q == OP_WR_IE;
  assign evt_btr0_wr   = second_b && opc_q == OP_WR_BTR0;
  assign evt_btr1_wr   = second_b && opc_q == OP_WR_BTR1;
  assign evt_intf_clr  = second_b && opc_q == OP_RD_INTF;
  assign evt_err_clr   = second_b && opc_q == OP_RD_ERR;

  assign stat_val = (mode_field(ctrl0_q) == MODE_INIT) ? STAT_RESET : stat_live_i;

  always_comb begin
    case (byte_data)
      OP_RD_CTRL0: rd_val = ctrl0_q;
      OP_RD_CTRL1: rd_val = ctrl1_q;
      OP_RD_STAT:  rd_val = stat_val;
      OP_RD_BTR0:  rd_val = btr0_q;
      OP_RD_BTR1:  rd_val = btr1_q;
      OP_RD_INTF:  rd_val = intf_q;
      OP_RD_ERR:   rd_val = err_q;
      OP_RD_REC:   rd_val = rec_i;
      OP_RD_TEC:   rd_val = tec_i;
      default:     rd_val = 8'h00;
    endcase
  end

  assign load_en   = first_b;
  assign load_data = rd_val;

  // Opcode and read snapshot, taken at the end of byte 0.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opc_q  <= 8'h00;
      snap_q <= 8'h00;
    end else if (first_b) begin
      opc_q  <= byte_data;
      snap_q <= rd_val;
    end
  end

  // Configuration registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl0_q <= CTRL0_RESET;
      ctrl1_q <= 8'h00;
      ie_q    <= 8'h00;
      btr0_q  <= 8'h00;
      btr1_q  <= 8'h00;
    end else if (evt_mst_reset) begin
      ctrl0_q <= CTRL0_RESET;
      ctrl1_q <= 8'h00;
      ie_q    <= 8'h00;
      btr0_q  <= 8'h00;
      btr1_q  <= 8'h00;
    end else begin
      if (evt_ctrl0_wr) ctrl0_q <= byte_data;
      if (evt_ctrl1_wr) ctrl1_q <= byte_data;
      if (evt_ie_wr)    ie_q    <= byte_data;
      if (evt_btr0_wr)  btr0_q  <= byte_data;
      if (evt_btr1_wr)  btr1_q  <= byte_data;
    end
  end

  // Sticky flags: interrupt flags are cleared by the reset command,
  // error flags only by a power-on reset or a completed read.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      intf_q <= 8'h00;
      err_q  <= 8'h00;
    end else begin
      if (evt_mst_reset) intf_q <= 8'h00;
      else intf_q <= flag_update(intf_q, evt_intf_clr ? snap_q : 8'h00, int_set_i);
      err_q <= flag_update(err_q, evt_err_clr ? snap_q : 8'h00, err_set_i);
    end
  end

  assign mode_o     = mode_field(ctrl0_q);
  assign tx_en_o    = ctrl1_q[7];
  assign btr0_o     = btr0_q;
  assign btr1_o     = btr1_q;
  assign irq_o      = |(intf_q & ie_q);
  assign intf_flags = intf_q;
  assign err_flags  = err_q;
endmodule

// File: rtl/can_spi_regif.sv
module can_spi_regif
  import can_spi_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       spi_sclk,
  input  logic       spi_cs_n,
  input  logic       spi_mosi,
  output logic       spi_miso,
  input  logic [7:0] stat_live_i,
  input  logic [7:0] err_set_i,
  input  logic [7:0] int_set_i,
  input  logic [7:0] rec_i,
  input  logic [7:0] tec_i,
  output logic [2:0] mode_o,
  output logic       tx_en_o,
  output logic [7:0] btr0_o,
  output logic [7:0] btr1_o,
  output logic       irq_o
);
  logic       sclk_rise, sclk_fall, cs_active, mosi_s;
  logic       byte_vld, load_en;
  logic [7:0] byte_data, load_data;
  logic [1:0] byte_idx;
  logic [7:0] intf_flags, err_flags;
  logic       evt_mst_reset, evt_ctrl0_wr, evt_ie_wr, evt_intf_clr, evt_err_clr;

  spi_sync_front #(.STAGES(SYNC_STAGES)) i_front (
    .clk, .rst_n,
    .sclk_raw(spi_sclk), .cs_n_raw(spi_cs_n), .mosi_raw(spi_mosi),
    .sclk_rise, .sclk_fall, .cs_active, .mosi_s
  );

  spi_byte_engine #(.BYTE_W(BYTE_W)) i_engine (
    .clk, .rst_n, .sclk_rise, .sclk_fall, .cs_active, .mosi_s,
    .load_en, .load_data, .byte_vld, .byte_data, .byte_idx,
    .miso(spi_miso)
  );

  can_reg_core i_core (
    .clk, .rst_n, .byte_vld, .byte_data, .byte_idx,
    .stat_live_i, .err_set_i, .int_set_i, .rec_i, .tec_i,
    .load_en, .load_data, .mode_o, .tx_en_o, .btr0_o, .btr1_o, .irq_o,
    .intf_flags, .err_flags,
    .evt_mst_reset, .evt_ctrl0_wr, .evt_ie_wr, .evt_intf_clr, .evt_err_clr
  );
endmodule

// File: rtl/can_spi_regif_chk.sv
module can_spi_regif_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       irq_o,
  input logic [2:0] mode_o,
  input logic [7:0] int_set_i,
  input logic [7:0] intf_flags,
  input logic [7:0] err_flags,
  input logic       evt_mst_reset,
  input logic       evt_ctrl0_wr,
  input logic       evt_ie_wr,
  input logic       evt_intf_clr,
  input logic       evt_err_clr
);
  // R4: the reset command lands in init mode
  assert_reset_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
    evt_mst_reset |=> mode_o == 3'd4);

  // R4: no error flag is lost across the reset command
  assert_err_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    evt_mst_reset |=> (($past(err_flags) & ~err_flags) == 8'h00));

  // R6: the request only rises after a new flag or an enable write
  assert_irq_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(int_set_i != 8'h00 || evt_ie_wr));

  // R8: interrupt flags fall only on a completed read or the reset command
  assert_intf_no_early_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(intf_flags) & ~intf_flags) != 8'h00) |-> $past(evt_intf_clr || evt_mst_reset));

  // R5: error flags fall only on a completed read
  assert_err_no_early_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(err_flags) & ~err_flags) != 8'h00) |-> $past(evt_err_clr));

  // R2: the mode only moves on a control-0 write or the reset command
  assert_mode_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(evt_ctrl0_wr || evt_mst_reset) |=> $stable(mode_o));
endmodule

bind can_spi_regif can_spi_regif_chk i_chk (
  .clk(clk), .rst_n(rst_n), .irq_o(irq_o), .mode_o(mode_o),
  .int_set_i(int_set_i), .intf_flags(intf_flags), .err_flags(err_flags),
  .evt_mst_reset(evt_mst_reset), .evt_ctrl0_wr(evt_ctrl0_wr),
  .evt_ie_wr(evt_ie_wr), .evt_intf_clr(evt_intf_clr), .evt_err_clr(evt_err_clr)
);

// File: tb/test_can_spi_regif.sv
`timescale 1ns/1ps
module test_can_spi_regif;
  localparam int HP = 8; // SCLK half period in system clocks

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic       spi_miso;
  logic [7:0] stat_live_i = 8'h1C, err_set_i = 8'h00, int_set_i = 8'h00;
  logic [7:0] rec_i = 8'h00, tec_i = 8'h00;
  logic [2:0] mode_o;
  logic       tx_en_o, irq_o;
  logic [7:0] btr0_o, btr1_o;

  int nchk = 0, nerr = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] obs_q[$];

  always #5 clk = ~clk;

  can_spi_regif i_can_spi_regif (
    .clk, .rst_n, .spi_sclk, .spi_cs_n, .spi_mosi, .spi_miso,
    .stat_live_i, .err_set_i, .int_set_i, .rec_i, .tec_i,
    .mode_o, .tx_en_o, .btr0_o, .btr1_o, .irq_o
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // One frame of nbytes; the MISO bits of byte 1 are returned.
  task automatic xfer(input int nbytes, input logic [7:0] b0, input logic [7:0] b1,
                      output logic [7:0] r1);
    logic [7:0] tx;
    r1 = 8'h00;
    spi_cs_n = 1'b0;
    for (int b = 0; b < nbytes; b++) begin
      tx = (b == 0) ? b0 : b1;
      for (int i = 7; i >= 0; i--) begin
        spi_mosi = tx[i];
        waitc(HP);
        if (b == 1) r1 = {r1[6:0], spi_miso};
        spi_sclk = 1'b1;
        waitc(HP);
        spi_sclk = 1'b0;
      end
    end
    waitc(HP);
    spi_cs_n = 1'b1;
    waitc(2 * HP);
  endtask

  task automatic wr(input logic [7:0] op, input logic [7:0] val);
    logic [7:0] d;
    xfer(2, op, val, d);
  endtask

  // Scoreboard driver: push expectation, then run the frame.
  task automatic rd(input logic [7:0] op, input logic [7:0] exp, input string tag);
    logic [7:0] d;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    xfer(2, op, 8'h00, d);
    obs_q.push_back(d);
  endtask

  task automatic pulse_err(input logic [7:0] v);
    err_set_i = v; waitc(1); err_set_i = 8'h00; waitc(2);
  endtask

  task automatic pulse_int(input logic [7:0] v);
    int_set_i = v; waitc(1); int_set_i = 8'h00; waitc(2);
  endtask

  // Scoreboard monitor.
  always @(negedge clk) begin
    while (obs_q.size() > 0 && exp_q.size() > 0) begin
      check(tag_q.pop_front(), obs_q.pop_front(), exp_q.pop_front());
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog R1..: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    waitc(5);
    rst_n = 1'b1;
    waitc(5);

    // Reset state
    check("R2 reset mode_o", {5'b0, mode_o}, 8'h04);
    check("R11 reset tx_en", {7'b0, tx_en_o}, 8'h00);
    check("R6 reset irq", {7'b0, irq_o}, 8'h00);
    rd(8'hD2, 8'h80, "R2 ctrl0 after reset");
    rd(8'hE2, 8'h82, "R3 status fixed in init");
    rd(8'hDC, 8'h00, "R5 err after reset");

    // R1 bit timing
    wr(8'h18, 8'h5A);
    wr(8'h1A, 8'hA7);
    rd(8'hD6, 8'h5A, "R1 btr0 readback");
    rd(8'hD8, 8'hA7, "R1 btr1 readback");
    check("R1 btr0_o", btr0_o, 8'h5A);
    check("R1 btr1_o", btr1_o, 8'hA7);

    // R11 transmit enable
    wr(8'h16, 8'h80);
    check("R11 tx_en set", {7'b0, tx_en_o}, 8'h01);
    rd(8'hD4, 8'h80, "R11 ctrl1 readback");

    // R2 modes, R3 live status
    wr(8'h14, 8'h60);
    check("R2 sleep mode", {5'b0, mode_o}, 8'h03);
    wr(8'h14, 8'h40);
    check("R2 monitor mode", {5'b0, mode_o}, 8'h02);
    wr(8'h14, 8'h20);
    check("R2 loopback mode", {5'b0, mode_o}, 8'h01);
    rd(8'hD2, 8'h20, "R2 ctrl0 readback");
    rd(8'hE2, 8'h1C, "R3 status live");

    // R5 error flags
    pulse_err(8'h15);
    pulse_err(8'h40);
    rd(8'hDC, 8'h55, "R5 err accumulate");
    rd(8'hDC, 8'h00, "R5 err cleared");

    // R6 / R7 / R8 interrupts
    wr(8'h1C, 8'h20);
    pulse_int(8'h40);
    check("R6 masked flag no irq", {7'b0, irq_o}, 8'h00);
    pulse_int(8'h20);
    check("R6 enabled flag irq", {7'b0, irq_o}, 8'h01);
    xfer(1, 8'hDE, 8'h00, d);
    check("R8 short read keeps irq", {7'b0, irq_o}, 8'h01);
    rd(8'hDE, 8'h60, "R7 intf read");
    check("R7 irq after clear", {7'b0, irq_o}, 8'h00);
    rd(8'hDE, 8'h00, "R7 intf cleared");

    // R8 short write
    xfer(1, 8'h18, 8'h00, d);
    rd(8'hD6, 8'h5A, "R8 short write ignored");

    // R9 counters
    rec_i = 8'h33; tec_i = 8'h7F;
    rd(8'hEA, 8'h33, "R9 rec");
    rd(8'hEC, 8'h7F, "R9 tec");

    // R10 unknown codes
    rd(8'h99, 8'h00, "R10 unknown read");
    wr(8'h30, 8'hFF);
    rd(8'hD2, 8'h20, "R10 ctrl0 untouched");
    rd(8'hD8, 8'hA7, "R10 btr1 untouched");

    // R4 master reset
    pulse_err(8'h81);
    wr(8'h1C, 8'h20);
    pulse_int(8'h20);
    check("R4 irq before reset", {7'b0, irq_o}, 8'h01);
    xfer(1, 8'h56, 8'h00, d);
    check("R4 mode init", {5'b0, mode_o}, 8'h04);
    check("R4 tx_en cleared", {7'b0, tx_en_o}, 8'h00);
    check("R4 irq cleared", {7'b0, irq_o}, 8'h00);
    check("R4 btr0_o cleared", btr0_o, 8'h00);
    rd(8'hD2, 8'h80, "R4 ctrl0 init");
    rd(8'hE2, 8'h82, "R4 status reset value");
    rd(8'hDE, 8'h00, "R4 intf cleared");
    rd(8'hDC, 8'h81, "R4 err survives");

    waitc(4);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule